// File: doc/BRIEF.md
# Single-Vector Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. It has three sources. The first is an edge on an external pin, and a selectable polarity decides which edge counts. The second is a timer event strobe. The third is a software trap, which the core signals when it fetches the all-zero opcode. Every source sends the core to the same fixed vector address. The block holds the global enable, the per-source enables, the two pending flags and the edge polarity. The core reads the enables and flags back through one status byte, in which each field keeps the bit position that the core's bit instructions decode.

When a hardware request is enabled, the core pulses an instruction-boundary strobe. The block then raises a one-cycle acknowledge and a PC-push request, and it clears the global enable. A return-from-interrupt strobe sets the global enable again. The software trap is not masked by the global enable and does not change it. It has the lowest rank: if an enabled hardware request is present in the same cycle, the trap is dropped, because the shared vector would make the two indistinguishable. Pending flags stay set until software writes them clear. Once the handler sets the global enable again, nested interrupts become possible.

Top module: `single_vector_irq`

## Requirements
- R1: After reset the status byte reads 0x00, the edge select reads 0, and hwAck, swAck and pushPc are low.
- R2: The external pin passes through two synchroniser flops before edge detection. A change of the pin that is present at clock edge k sets the external pending flag (status bit 3) at edge k+2, so it is visible after three edges counted from k. The change must be rising when edge select is 1 and falling when edge select is 0.
- R3: A timerEvent pulse sets the timer pending flag (status bit 5) at the next clock edge.
- R4: A hardware request exists when the global enable (bit 0) is set and either the external enable (bit 1) and external pending (bit 3) are both set, or the timer enable (bit 4) and timer pending (bit 5) are both set. The request is accepted only in a cycle where boundary is high. Acceptance makes hwAck and pushPc high for exactly the following cycle.
- R5: Accepting a hardware request clears the global enable and leaves both pending flags unchanged.
- R6: retStrobe sets the global enable at the next edge. If a hardware acceptance happens in the same cycle, the acceptance wins and the global enable is cleared.
- R7: trapFetch in a cycle with no hardware request gives one cycle of swAck and pushPc. This happens whatever the value of the global enable, and the global enable is left unchanged.
- R8: trapFetch in a cycle with a hardware request present is lost: swAck stays low.
- R9: vectorAddr always presents 0x00FF.
- R10: statusWrEn loads bits 0, 1, 3, 4 and 5 from statusWrData. Bits 2, 6 and 7 always read 0. A pending-flag set event in the same cycle wins over a written 0.
- R11: edgeWrEn loads edge select from edgeWrData, and edgeSelOut reports it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| extPin | input | 1 | Asynchronous external interrupt pin |
| timerEvent | input | 1 | Timer underflow or capture pulse |
| trapFetch | input | 1 | Opcode-zero fetch strobe |
| retStrobe | input | 1 | Return-from-interrupt strobe |
| boundary | input | 1 | Instruction-boundary strobe |
| statusWrEn | input | 1 | Status byte write enable |
| statusWrData | input | 8 | Status byte write value |
| edgeWrEn | input | 1 | Edge select write enable |
| edgeWrData | input | 1 | Edge select value (1 rising, 0 falling) |
| statusOut | output | 8 | Status byte readback |
| edgeSelOut | output | 1 | Edge select readback |
| hwAck | output | 1 | Hardware interrupt acknowledge pulse |
| swAck | output | 1 | Software trap acknowledge pulse |
| pushPc | output | 1 | Request to push the PC and jump |
| vectorAddr | output | 15 | Fixed interrupt vector |

## Verification
A wrong enable or pending bit is visible on statusOut after the next clock edge. It also shows up as a missing or extra hwAck on the next boundary strobe. A synchroniser that is too short or too long moves the setting of the external pending flag by one edge, and the cycle-by-cycle comparison catches that directly. A fault in the trap masking shows as an swAck pulse one cycle after a trapFetch that coincides with an enabled request, or as a change of the global enable after a trap. Both are seen within a single cycle.

// File: rtl/irqPkg.sv
package irqPkg;
  localparam int BIT_GIE  = 0;
  localparam int BIT_ENI  = 1;
  localparam int BIT_IPND = 3;
  localparam int BIT_ENTI = 4;
  localparam int BIT_TPND = 5;

  typedef struct packed {
    logic hwTake;
    logic swTake;
    logic clrGie;
    logic setGie;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irqPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        extPin,
  input  logic        timerEvent,
  input  logic        statusWrEn,
  input  logic [7:0]  statusWrData,
  input  logic        edgeWrEn,
  input  logic        edgeWrData,
  input  ctrlStrobe_t strobe,
  output logic        hwReq,
  output logic [7:0]  statusOut,
  output logic        edgeSelOut
);
  localparam logic [7:0] HELD_MASK = 8'((1 << BIT_GIE) | (1 << BIT_ENI) |
    (1 << BIT_IPND) | (1 << BIT_ENTI) | (1 << BIT_TPND));

  logic [SYNC_STAGES-1:0] syncQ;
  logic prevQ;
  logic edgeSelQ;
  logic extEdge;
  logic [7:0] statQ, nextStat;

  // pin synchroniser, depth chosen by parameter
  genvar i;
  generate
    for (i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else if (i == 0) syncQ[i] <= extPin;
        else syncQ[i] <= syncQ[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevQ    <= 1'b0;
      edgeSelQ <= 1'b0;
      statQ    <= 8'h00;
    end else begin
      prevQ <= syncQ[SYNC_STAGES-1];
      if (edgeWrEn) edgeSelQ <= edgeWrData;
      statQ <= nextStat;
    end
  end

  assign extEdge = edgeSelQ ? (syncQ[SYNC_STAGES-1] & ~prevQ)
                            : (~syncQ[SYNC_STAGES-1] & prevQ);

  always_comb begin
    nextStat = (statusWrEn ? statusWrData : statQ) & HELD_MASK;
    nextStat[BIT_IPND] = nextStat[BIT_IPND] | extEdge;
    nextStat[BIT_TPND] = nextStat[BIT_TPND] | timerEvent;
    if (strobe.clrGie)      nextStat[BIT_GIE] = 1'b0;
    else if (strobe.setGie) nextStat[BIT_GIE] = 1'b1;
  end

  assign hwReq = statQ[BIT_GIE] &
                 ((statQ[BIT_ENI] & statQ[BIT_IPND]) |
                  (statQ[BIT_ENTI] & statQ[BIT_TPND]));
  assign statusOut  = statQ;
  assign edgeSelOut = edgeSelQ;
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        boundary,
  input  logic        trapFetch,
  input  logic        retStrobe,
  input  logic        hwReq,
  output ctrlStrobe_t strobe,
  output logic        hwAck,
  output logic        swAck,
  output logic        pushPc
);
  always_comb begin
    strobe.hwTake = boundary & hwReq;
    strobe.swTake = trapFetch & ~hwReq;
    strobe.clrGie = strobe.hwTake;
    strobe.setGie = retStrobe & ~strobe.hwTake;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hwAck  <= 1'b0;
      swAck  <= 1'b0;
      pushPc <= 1'b0;
    end else begin
      hwAck  <= strobe.hwTake;
      swAck  <= strobe.swTake;
      pushPc <= strobe.hwTake | strobe.swTake;
    end
  end
endmodule

// File: rtl/single_vector_irq.sv
module single_vector_irq
  import irqPkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          ADDR_W      = 15,
  parameter logic [14:0] VECTOR_ADDR = 15'h00FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              extPin,
  input  logic              timerEvent,
  input  logic              trapFetch,
  input  logic              retStrobe,
  input  logic              boundary,
  input  logic              statusWrEn,
  input  logic [7:0]        statusWrData,
  input  logic              edgeWrEn,
  input  logic              edgeWrData,
  output logic [7:0]        statusOut,
  output logic              edgeSelOut,
  output logic              hwAck,
  output logic              swAck,
  output logic              pushPc,
  output logic [ADDR_W-1:0] vectorAddr
);
  ctrlStrobe_t strobe;
  logic hwReq;

  irq_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .extPin(extPin), .timerEvent(timerEvent),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .edgeWrEn(edgeWrEn), .edgeWrData(edgeWrData), .strobe(strobe),
    .hwReq(hwReq), .statusOut(statusOut), .edgeSelOut(edgeSelOut)
  );

  irq_control u_ctl (
    .clk(clk), .rstN(rstN), .boundary(boundary), .trapFetch(trapFetch),
    .retStrobe(retStrobe), .hwReq(hwReq), .strobe(strobe),
    .hwAck(hwAck), .swAck(swAck), .pushPc(pushPc)
  );

  assign vectorAddr = ADDR_W'(VECTOR_ADDR);
endmodule

// File: rtl/single_vector_irq_chk.sv
module single_vector_irq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       timerEvent,
  input logic       retStrobe,
  input logic       statusWrEn,
  input logic [7:0] statusOut,
  input logic       hwAck,
  input logic       swAck,
  input logic       pushPc
);
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    hwAck |=> !hwAck); // R4
  AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    hwAck |-> $past(statusOut[0]) &&
      (($past(statusOut[1]) && $past(statusOut[3])) ||
       ($past(statusOut[4]) && $past(statusOut[5])))); // R4
  AST_ACK_PUSHES: assert property (@(posedge clk) disable iff (!rstN)
    (hwAck || swAck) |-> pushPc); // R4
  AST_ACK_DROPS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    hwAck |-> !statusOut[0]); // R5
  AST_RET_RAISES_GIE: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |=> (statusOut[0] || hwAck)); // R6
  AST_TRAP_KEEPS_GIE: assert property (@(posedge clk) disable iff (!rstN)
    (swAck && !$past(retStrobe) && !$past(statusWrEn)) |-> $stable(statusOut[0])); // R7
  AST_NO_DOUBLE_ACK: assert property (@(posedge clk) disable iff (!rstN)
    !(hwAck && swAck)); // R8
  AST_TIMER_PEND: assert property (@(posedge clk) disable iff (!rstN)
    timerEvent |=> statusOut[5]); // R3
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !statusOut[2] && !statusOut[6] && !statusOut[7]); // R10
endmodule

bind single_vector_irq single_vector_irq_chk u_chk (
  .clk(clk), .rstN(rstN), .timerEvent(timerEvent), .retStrobe(retStrobe),
  .statusWrEn(statusWrEn), .statusOut(statusOut), .hwAck(hwAck),
  .swAck(swAck), .pushPc(pushPc)
);

// File: tb/single_vector_irq_test.sv
`timescale 1ns/1ps
module single_vector_irq_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic extPin = 1'b0, timerEvent = 1'b0, trapFetch = 1'b0, retStrobe = 1'b0;
  logic boundary = 1'b0, statusWrEn = 1'b0, edgeWrEn = 1'b0, edgeWrData = 1'b0;
  logic [7:0] statusWrData = 8'h00;
  logic [7:0] statusOut;
  logic edgeSelOut, hwAck, swAck, pushPc;
  logic [14:0] vectorAddr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  single_vector_irq uut (
    .clk(clk), .rstN(rstN), .extPin(extPin), .timerEvent(timerEvent),
    .trapFetch(trapFetch), .retStrobe(retStrobe), .boundary(boundary),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .edgeWrEn(edgeWrEn), .edgeWrData(edgeWrData), .statusOut(statusOut),
    .edgeSelOut(edgeSelOut), .hwAck(hwAck), .swAck(swAck), .pushPc(pushPc),
    .vectorAddr(vectorAddr)
  );

  // behavioural reference model
  bit pinHist[$];
  bit mGie, mEni, mIpnd, mEnti, mTpnd, mSel, mHw, mSw;

  function automatic logic [7:0] mStatus();
    return {2'b00, mTpnd, mEnti, mIpnd, 1'b0, mEni, mGie};
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      pinHist = {1'b0, 1'b0, 1'b0};
      {mGie, mEni, mIpnd, mEnti, mTpnd, mSel, mHw, mSw} = '0;
    end else begin
      bit req, take, trap, cur, prev, ev;
      bit nGie, nEni, nIpnd, nEnti, nTpnd;
      req  = mGie && ((mEni && mIpnd) || (mEnti && mTpnd));
      take = boundary && req;
      trap = trapFetch && !req;
      cur  = pinHist[pinHist.size()-2];
      prev = pinHist[pinHist.size()-3];
      ev   = mSel ? (cur && !prev) : (!cur && prev);
      nGie = statusWrEn ? statusWrData[0] : mGie;
      nEni = statusWrEn ? statusWrData[1] : mEni;
      nIpnd = (statusWrEn ? statusWrData[3] : mIpnd) || ev;
      nEnti = statusWrEn ? statusWrData[4] : mEnti;
      nTpnd = (statusWrEn ? statusWrData[5] : mTpnd) || timerEvent;
      if (take) nGie = 0;
      else if (retStrobe) nGie = 1;
      if (edgeWrEn) mSel = edgeWrData;
      {mGie, mEni, mIpnd, mEnti, mTpnd} = {nGie, nEni, nIpnd, nEnti, nTpnd};
      mHw = take;
      mSw = trap;
      pinHist.push_back(extPin);
      if (pinHist.size() > 4) void'(pinHist.pop_front());
    end
  end

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    chk("R10 status vs model", 16'(statusOut), 16'(mStatus()));
    chk("R4 hwAck vs model", 16'(hwAck), 16'(mHw));
    chk("R7 swAck vs model", 16'(swAck), 16'(mSw));
    chk("R4 pushPc vs model", 16'(pushPc), 16'(mHw | mSw));
    chk("R11 edgeSel vs model", 16'(edgeSelOut), 16'(mSel));
    chk("R9 vector", 16'(vectorAddr), 16'h00FF);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compareAll();
    timerEvent = 0; trapFetch = 0; retStrobe = 0; boundary = 0;
    statusWrEn = 0; edgeWrEn = 0;
  endtask

  task automatic wrStatus(logic [7:0] v);
    statusWrEn = 1; statusWrData = v;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tick();
    chk("R1 reset status", 16'(statusOut), 16'h00);
    chk("R1 reset acks", 16'({hwAck, swAck, pushPc, edgeSelOut}), 16'h0);

    // rising edge, external source enabled
    edgeWrEn = 1; edgeWrData = 1; wrStatus(8'h03);
    tick();
    chk("R11 edge select readback", 16'(edgeSelOut), 16'h1);
    extPin = 1;
    tick(); tick();
    chk("R2 pending not yet", 16'(statusOut[3]), 16'h0);
    tick();
    chk("R2 rising edge pending", 16'(statusOut[3]), 16'h1);
    boundary = 1;
    tick();
    chk("R4 hw ack", 16'({hwAck, pushPc}), 16'h3);
    chk("R5 gie cleared, pending kept", 16'(statusOut), 16'h0A);
    boundary = 1;
    tick();
    chk("R4 ack single cycle, masked", 16'(hwAck), 16'h0);
    retStrobe = 1;
    tick();
    chk("R6 ret sets gie", 16'(statusOut[0]), 16'h1);
    wrStatus(8'h03);
    tick();

    // falling edge
    edgeWrEn = 1; edgeWrData = 0;
    tick();
    extPin = 0;
    tick(); tick(); tick();
    chk("R2 falling edge pending", 16'(statusOut[3]), 16'h1);
    wrStatus(8'h01);
    tick();

    // trap with gie set and no request
    trapFetch = 1;
    tick();
    chk("R7 trap acked", 16'({swAck, pushPc}), 16'h3);
    chk("R7 gie unchanged", 16'(statusOut[0]), 16'h1);

    // timer request coinciding with trap
    wrStatus(8'h11);
    tick();
    timerEvent = 1;
    tick();
    chk("R3 timer pending", 16'(statusOut[5]), 16'h1);
    trapFetch = 1; boundary = 1;
    tick();
    chk("R8 trap lost", 16'(swAck), 16'h0);
    chk("R8 hw wins", 16'(hwAck), 16'h1);
    trapFetch = 1;
    tick();
    chk("R7 trap with gie clear", 16'(swAck), 16'h1);
    chk("R7 gie stays clear", 16'(statusOut[0]), 16'h0);

    // status write masking and set priority
    wrStatus(8'hFF);
    tick();
    chk("R10 spare bits zero", 16'(statusOut), 16'h3B);
    wrStatus(8'h00); timerEvent = 1;
    tick();
    chk("R10 set beats clear", 16'(statusOut), 16'h20);

    // ret coinciding with acceptance
    wrStatus(8'h31);
    tick();
    retStrobe = 1; boundary = 1;
    tick();
    chk("R6 acceptance beats ret", 16'({hwAck, statusOut[0]}), 16'h2);
    repeat (4) tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule